// File: doc/BRIEF.md
# Two-Bit Grayscale TMDS Symbol Encoder

This block turns packed 2-bit pixels into 10-bit TMDS data symbols at full horizontal resolution. Each pixel carries one of four intensity levels (2-bit grayscale, or one colour plane of a 2-bit-per-channel RGB image). It does no running-disparity calculation. Each level maps to a fixed codeword that depends on the pixel's x parity. Even pixels take a codeword with four more zeros than ones. Odd pixels take a codeword with four more ones than zeros. Any even/odd pair therefore sums to zero disparity, whatever the two levels are.

A second codeword set, chosen by `flat_mode`, uses symbols with equal ones and zeros for every level. It gives lower contrast but no alternation between even and odd pixels. The mode is captured only on a `line_start` pulse, so one line never mixes the two sets.

Input arrives as 32-bit words holding 16 pixels over a valid/ready handshake. Output leaves as 20-bit words holding one even/odd symbol pair, also over valid/ready, eight output words per input word. When `out_ready` is low, the output word and `out_valid` hold. `in_ready` stays low while a word still has pairs to send. The only exception is the last pair: if it is accepted in the same cycle, a new word can be taken without a gap cycle.

Top module: `gray2_tmds_enc`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1, and the codeword set is the alternating one (`flat_mode` latched as 0).
- R2: In alternating mode, the even-pixel symbol for levels 0, 1, 2 and 3 is 0x103, 0x130, 0x230 and 0x203.
- R3: In alternating mode, the odd-pixel symbol for levels 0, 1, 2 and 3 is 0x1FC, 0x1CF, 0x2CF and 0x2FC.
- R4: In flat mode, levels 0, 1, 2 and 3 map to 0x1F0, 0x263, 0x163 and 0x2F0 for both parities.
- R5: Pixel i of an input word is bits [2i+1:2i]. Output word k carries pixel 2k's symbol in bits [9:0] and pixel 2k+1's symbol in bits [19:10]. Output words leave in ascending k.
- R6: Each accepted input word yields exactly 8 output words. `out_valid` is high exactly while pairs remain. `in_ready` is high when no pairs remain, or when the last pair is being accepted in that cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_word` hold their values into the next cycle.
- R8: `flat_mode` is latched only in a cycle where `line_start` is 1. Changes at any other time have no effect on the symbols.
- R9: Every output word contains exactly ten 1 bits, so each pair is DC balanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at line start; latches `flat_mode` |
| flat_mode | input | 1 | 1 selects zero-disparity codewords, 0 selects alternating codewords |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| in_word | input | 32 | 16 packed 2-bit pixels, pixel 0 in the LSBs |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the output pair |
| out_word | output | 20 | Odd symbol in [19:10], even symbol in [9:0] |

## Verification
The bench runs input words built from uniform levels, ascending and descending level ramps and random data, so a swapped level code, a swapped parity or a reversed pair order shows up as a wrong half of an output word. It throttles both sides at random. A design that dropped or repeated a pair, changed its output during a stall, or needed a bubble between words would then miscompare or break the ready prediction. One line toggles `flat_mode` every cycle without a `line_start`; a design that read the mode live would emit flat codewords in the middle of an alternating line.

// File: rtl/gray2_tmds_pkg.sv
package gray2_tmds_pkg;
  localparam int SYM_W = 10;
  localparam int LVL_W = 2;
  typedef logic [SYM_W-1:0] sym_t;

  // Fixed codeword for one pixel: level, x parity, codeword set.
  function automatic sym_t level_symbol(input logic [LVL_W-1:0] lvl,
                                        input logic odd, input logic flat);
    sym_t s;
    if (flat) begin
      case (lvl)
        2'd0:    s = 10'h1F0;
        2'd1:    s = 10'h263;
        2'd2:    s = 10'h163;
        default: s = 10'h2F0;
      endcase
    end else if (!odd) begin
      case (lvl)
        2'd0:    s = 10'h103;
        2'd1:    s = 10'h130;
        2'd2:    s = 10'h230;
        default: s = 10'h203;
      endcase
    end else begin
      case (lvl)
        2'd0:    s = 10'h1FC;
        2'd1:    s = 10'h1CF;
        2'd2:    s = 10'h2CF;
        default: s = 10'h2FC;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/gray2_sym_lut.sv
module gray2_sym_lut
  import gray2_tmds_pkg::*;
#(
  parameter bit ODD = 1'b0
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic             flat,
  output sym_t             sym
);
  always_comb sym = level_symbol(lvl, ODD, flat);
endmodule

// File: rtl/gray2_pair_enc.sv
module gray2_pair_enc
  import gray2_tmds_pkg::*;
#(
  parameter int PIX_PER_BEAT = 2
) (
  input  logic [PIX_PER_BEAT*LVL_W-1:0] pix,
  input  logic                          flat,
  output logic [PIX_PER_BEAT*SYM_W-1:0] syms
);
  for (genvar p = 0; p < PIX_PER_BEAT; p++) begin : g_pix
    sym_t s;
    gray2_sym_lut #(.ODD(p % 2 == 1)) u_lut (
      .lvl  (pix[p*LVL_W +: LVL_W]),
      .flat (flat),
      .sym  (s)
    );
    assign syms[p*SYM_W +: SYM_W] = s;
  end
endmodule

// File: rtl/gray2_word_slicer.sv
module gray2_word_slicer #(
  parameter int IN_W   = 32,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] beat
);
  localparam int BEATS = IN_W / BEAT_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [IN_W-1:0]   word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic [BEAT_W-1:0] slices [BEATS];

  for (genvar k = 0; k < BEATS; k++) begin : g_slice
    assign slices[k] = word_q[k*BEAT_W +: BEAT_W];
  end

  logic out_fire, last_beat, in_fire;
  assign out_fire  = busy_q && out_ready;
  assign last_beat = (idx_q == IDX_W'(BEATS - 1));
  assign in_ready  = !busy_q || (out_fire && last_beat);
  assign in_fire   = in_valid && in_ready;
  assign out_valid = busy_q;
  assign beat      = slices[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (in_fire) begin
      word_q <= in_word;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (out_fire) begin
      idx_q <= last_beat ? '0 : idx_q + 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gray2_tmds_enc.sv
module gray2_tmds_enc
  import gray2_tmds_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  logic                 flat_mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*SYM_W-1:0]   out_word
);
  localparam int BEAT_W = 2 * LVL_W;

  logic              flat_q;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n)          flat_q <= 1'b0;
    else if (line_start) flat_q <= flat_mode;
  end

  gray2_word_slicer #(.IN_W(IN_W), .BEAT_W(BEAT_W)) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .beat      (beat)
  );

  gray2_pair_enc #(.PIX_PER_BEAT(2)) u_pair (
    .pix  (beat),
    .flat (flat_q),
    .syms (out_word)
  );
endmodule

// File: rtl/gray2_tmds_enc_chk.sv
module gray2_tmds_enc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [19:0] out_word
);
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_word));

  p_dc_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_word) == 10));

  p_ready_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && (!out_ready || $countones(out_word) == 10)));

  p_stall_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind gray2_tmds_enc gray2_tmds_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word)
);

// File: tb/gray2_tmds_enc_tb.sv
module gray2_tmds_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        flat_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [19:0] out_word;

  int vectors = 0;
  int fails   = 0;
  bit mode_ref = 1'b0;
  bit stalled  = 1'b0;
  string ctx = "R5";
  logic [19:0] q[$];

  always #5 clk = ~clk;

  gray2_tmds_enc u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .flat_mode(flat_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  function automatic logic [9:0] ref_sym(int lvl, bit odd, bit flat);
    int even_t [4] = '{'h103, 'h130, 'h230, 'h203};
    int odd_t  [4] = '{'h1FC, 'h1CF, 'h2CF, 'h2FC};
    int flat_t [4] = '{'h1F0, 'h263, 'h163, 'h2F0};
    if (flat) return 10'(flat_t[lvl]);
    return odd ? 10'(odd_t[lvl]) : 10'(even_t[lvl]);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(bit iv, logic [31:0] w, bit ordy, bit ls, bit fm);
    bit ofire, ifire;
    @(negedge clk);
    in_valid = iv; in_word = w; out_ready = ordy; line_start = ls; flat_mode = fm;
    #1;
    check(out_valid == (q.size() != 0), "R6 out_valid", 32'(out_valid), 32'(q.size() != 0));
    check(in_ready == (q.size() == 0 || (q.size() == 1 && ordy)), "R6 in_ready",
          32'(in_ready), 32'(q.size() == 0 || (q.size() == 1 && ordy)));
    if (out_valid && q.size() != 0) begin
      check(out_word[9:0] == q[0][9:0],
            $sformatf("%s even half (%s%s)", mode_ref ? "R4" : "R2", ctx, stalled ? " R7" : ""),
            32'(out_word[9:0]), 32'(q[0][9:0]));
      check(out_word[19:10] == q[0][19:10],
            $sformatf("%s odd half (%s%s)", mode_ref ? "R4" : "R3", ctx, stalled ? " R7" : ""),
            32'(out_word[19:10]), 32'(q[0][19:10]));
      check($countones(out_word) == 10, "R9 balance", 32'($countones(out_word)), 32'd10);
    end
    ofire = out_valid && ordy;
    ifire = iv && in_ready;
    stalled = out_valid && !ordy;
    if (ofire && q.size() != 0) void'(q.pop_front());
    if (ls) mode_ref = fm;
    if (ifire) begin
      for (int k = 0; k < 8; k++) begin
        int le = int'(w[4*k +: 2]);
        int lo = int'(w[4*k+2 +: 2]);
        q.push_back({ref_sym(lo, 1'b1, mode_ref), ref_sym(le, 1'b0, mode_ref)});
      end
    end
  endtask

  task automatic run_line(bit fm, bit toggle, int pin, int pout, logic [31:0] words[$]);
    int i = 0;
    int guard = 0;
    while (q.size() != 0 && guard < 200) begin cycle(0, '0, 1, 0, fm); guard++; end
    cycle(0, '0, 1, 1, fm);
    guard = 0;
    while ((i < words.size() || q.size() != 0) && guard < 5000) begin
      bit iv   = (i < words.size()) && (($urandom % 100) < pin);
      bit ordy = ($urandom % 100) < pout;
      bit fmx  = toggle ? ~(guard[0] ^ fm) : fm;
      logic [31:0] w = (i < words.size()) ? words[i] : '0;
      bit fire = iv && (q.size() == 0 || (q.size() == 1 && ordy));
      cycle(iv, w, ordy, 0, fmx);
      if (fire) i++;
      guard++;
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats[$];
    logic [31:0] rnd[$];
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    // R1: default set is alternating; send one word without a line_start
    ctx = "R1";
    cycle(1, 32'hE4E4E4E4, 1, 0, 1);
    for (int k = 0; k < 10; k++) cycle(0, '0, 1, 0, 1);

    pats = '{32'h00000000, 32'hFFFFFFFF, 32'h55555555, 32'hAAAAAAAA,
             32'hE4E4E4E4, 32'h1B1B1B1B, 32'h0123CDEF, 32'hFEDC3210};
    for (int k = 0; k < 24; k++) rnd.push_back($urandom);

    ctx = "R5"; run_line(0, 0, 100, 100, pats);
    ctx = "R5"; run_line(0, 0, 60, 50, rnd);
    ctx = "R5"; run_line(1, 0, 100, 100, pats);
    ctx = "R5"; run_line(1, 0, 50, 40, rnd);
    ctx = "R8"; run_line(0, 1, 80, 70, pats);
    ctx = "R8"; run_line(1, 1, 80, 70, rnd);
    ctx = "R6"; run_line(0, 0, 100, 20, rnd);
    for (int k = 0; k < 12; k++) cycle(0, '0, 1, 0, 0);
    check(q.size() == 0, "R6 all pairs delivered", 32'(q.size()), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule